// File: doc/BRIEF.md
# Paired Interrupt Aggregator with Vector Acknowledge

This block gathers interrupt sources from eight serial channels and presents them to a host as two level-sensitive interrupt lines. The channels are organised as four groups of two. Each group keeps an 8-bit status register, with one bit per source, and an 8-bit mask register. Channel controllers raise and drop status bits through per-channel set and clear strobes for three source kinds: transmitter ready, receiver ready and break change. A line is asserted while any group that feeds it has a status bit whose mask bit is also set. Groups 0 and 1 drive line 0, and groups 2 and 3 drive line 1.

The host reaches the block over a simple single-cycle register bus with four address spaces. In the I/O space, one offset per group loads that group's mask on a write and returns its status on a read. The host stores a one-byte interrupt vector by writing offset 1 of either the identification space or the memory space. An acknowledge read in the interrupt space returns that vector: offset 0 acknowledges line 0 and offset 2 acknowledges line 1. Two bit positions in each status register are reserved for counter and input-change sources. They have no source here and always read as zero.

Top module: `irq_pair_aggregator`

## Requirements
- R1: After reset, every status register, every mask register and the vector are zero, and both interrupt lines are low.
- R2: Source kinds map to status bits as follows: transmitter ready is kind 0, receiver ready is kind 1 and break change is kind 2. A set strobe for kind k of channel c sets bit k + 4*(c mod 2) in the status register of group c/2. The new bit is visible from the first clock edge after the strobe.
- R3: A status bit stays set until a clear strobe for the same channel and kind arrives, and that strobe clears only that bit. If a set and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R4: Status bits 3 and 7 of every group always read as zero, even when all of the group's set strobes are active together.
- R5: In I/O space the address carries the group in bits [7:6] and the register offset in bits [5:0]; status and mask share offset 0x05. A bus space code is one of I/O = 0, identification = 1, interrupt = 2 and memory = 3. A write at the shared offset loads that group's mask and leaves its status unchanged. A read at the shared offset returns the status, never the mask.
- R6: Line 0 is high while (status AND mask) is nonzero in group 0 or group 1. Line 1 is high under the same rule for groups 2 and 3. A line follows a status or mask change from the first clock edge after that change.
- R7: An interrupt-space read at address 0 or address 2 returns the stored vector. An interrupt-space read at any other address returns zero. Acknowledge reads change no state.
- R8: A write at address 1 of the identification space or the memory space loads the vector. Writes at any other address of those spaces, and all writes to the interrupt space, leave the vector unchanged.
- R9: I/O-space reads at offsets other than 0x05 return zero. I/O-space writes at those offsets change no mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_space | input | 2 | Address space: 0 I/O, 1 identification, 2 interrupt, 3 memory |
| bus_addr | input | 8 | Byte address within the selected space |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe; takes effect at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; zero when no read is active |
| set_tx | input | 8 | Per-channel transmitter-ready set strobes |
| set_rx | input | 8 | Per-channel receiver-ready set strobes |
| set_brk | input | 8 | Per-channel break-change set strobes |
| clr_tx | input | 8 | Per-channel transmitter-ready clear strobes |
| clr_rx | input | 8 | Per-channel receiver-ready clear strobes |
| clr_brk | input | 8 | Per-channel break-change clear strobes |
| irq_o | output | 2 | Level interrupt lines; bit l is line l |

## Verification
A status bit landing in the wrong position or group shows up on the next status read of that group. It also shows up on an interrupt line, one clock edge after the strobe, once the host has unmasked that position. A mask register that fails to load, or a mask written into the wrong group, shows up as an interrupt line that is high or low at the wrong time in the cycle after the mask write. A corrupted or unprotected vector register is seen on the very next acknowledge read at either line's offset.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int STAT_W   = 8;
    localparam int KIND_TX  = 0;
    localparam int KIND_RX  = 1;
    localparam int KIND_BRK = 2;
    localparam int ODD_BASE = 4;

    typedef enum logic [1:0] {
        SPACE_IO  = 2'd0,
        SPACE_ID  = 2'd1,
        SPACE_ACK = 2'd2,
        SPACE_MEM = 2'd3
    } space_e;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
    } grp_state_t;

    function automatic logic [2:0] stat_pos(input int parity, input int kind);
        return 3'(parity * ODD_BASE + kind);
    endfunction

endpackage

// File: rtl/irqagg_group.sv
module irqagg_group
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tx_set,
    input  logic [1:0]        rx_set,
    input  logic [1:0]        brk_set,
    input  logic [1:0]        tx_clr,
    input  logic [1:0]        rx_clr,
    input  logic [1:0]        brk_clr,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] mask_q
);

    grp_state_t        st_d, st_q;
    logic [STAT_W-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int p = 0; p < 2; p++) begin
            set_vec[stat_pos(p, KIND_TX)]  = tx_set[p];
            set_vec[stat_pos(p, KIND_RX)]  = rx_set[p];
            set_vec[stat_pos(p, KIND_BRK)] = brk_set[p];
            clr_vec[stat_pos(p, KIND_TX)]  = tx_clr[p];
            clr_vec[stat_pos(p, KIND_RX)]  = rx_clr[p];
            clr_vec[stat_pos(p, KIND_BRK)] = brk_clr[p];
        end
        st_d        = st_q;
        // set applied after clear: a simultaneous pair leaves the bit set
        st_d.status = (st_q.status & ~clr_vec) | set_vec;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.status;
    assign mask_q   = st_q.mask;

endmodule

// File: rtl/irqagg_vector.sv
module irqagg_vector #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] vec_q
);

    logic [DATA_W-1:0] vec_d, vec_r_q;

    always_comb begin
        vec_d = vec_r_q;
        if (wr_en) begin
            vec_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_r_q <= '0;
        end else begin
            vec_r_q <= vec_d;
        end
    end

    assign vec_q = vec_r_q;

endmodule

// File: rtl/irqagg_line.sv
module irqagg_line
    import irqagg_pkg::*;
#(
    parameter int GPL = 2
) (
    input  logic [GPL-1:0][STAT_W-1:0] status,
    input  logic [GPL-1:0][STAT_W-1:0] mask,
    output logic                       irq
);

    always_comb begin
        irq = 1'b0;
        for (int i = 0; i < GPL; i++) begin
            irq = irq | (|(status[i] & mask[i]));
        end
    end

endmodule

// File: rtl/irq_pair_aggregator.sv
module irq_pair_aggregator
    import irqagg_pkg::*;
#(
    parameter int NUM_CHANNELS = 8,
    parameter int GPL          = 2,
    parameter int ADDR_W       = 8,
    parameter int STAT_OFS     = 5,
    parameter int VEC_OFS      = 1,
    parameter int ACK_STRIDE   = 2,
    localparam int NUM_GROUPS  = NUM_CHANNELS / 2,
    localparam int NUM_LINES   = NUM_GROUPS / GPL,
    localparam int GRP_W       = $clog2(NUM_GROUPS),
    localparam int OFS_W       = ADDR_W - GRP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              bus_space,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [STAT_W-1:0]       bus_wdata,
    output logic [STAT_W-1:0]       bus_rdata,
    input  logic [NUM_CHANNELS-1:0] set_tx,
    input  logic [NUM_CHANNELS-1:0] set_rx,
    input  logic [NUM_CHANNELS-1:0] set_brk,
    input  logic [NUM_CHANNELS-1:0] clr_tx,
    input  logic [NUM_CHANNELS-1:0] clr_rx,
    input  logic [NUM_CHANNELS-1:0] clr_brk,
    output logic [NUM_LINES-1:0]    irq_o
);

    logic [NUM_GROUPS-1:0][STAT_W-1:0] grp_status;
    logic [NUM_GROUPS-1:0][STAT_W-1:0] grp_mask;
    logic [NUM_GROUPS-1:0]             mask_we;
    logic [STAT_W-1:0]                 vec_q;
    logic                              vec_we;
    logic [GRP_W-1:0]                  io_group;
    logic [OFS_W-1:0]                  io_ofs;
    logic                              io_stat_hit;

    assign io_group    = bus_addr[ADDR_W-1 -: GRP_W];
    assign io_ofs      = bus_addr[OFS_W-1:0];
    assign io_stat_hit = (bus_space == SPACE_IO) && (io_ofs == OFS_W'(STAT_OFS));

    // vector is accepted from the identification or memory space only
    assign vec_we = bus_wr && (bus_addr == ADDR_W'(VEC_OFS)) &&
                    ((bus_space == SPACE_ID) || (bus_space == SPACE_MEM));

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            assign mask_we[g] = bus_wr && io_stat_hit && (io_group == GRP_W'(g));

            irqagg_group u_grp (
                .clk        (clk),
                .rst_n      (rst_n),
                .tx_set     (set_tx[2*g +: 2]),
                .rx_set     (set_rx[2*g +: 2]),
                .brk_set    (set_brk[2*g +: 2]),
                .tx_clr     (clr_tx[2*g +: 2]),
                .rx_clr     (clr_rx[2*g +: 2]),
                .brk_clr    (clr_brk[2*g +: 2]),
                .mask_we    (mask_we[g]),
                .mask_wdata (bus_wdata),
                .status_q   (grp_status[g]),
                .mask_q     (grp_mask[g])
            );
        end

        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            irqagg_line #(.GPL(GPL)) u_line (
                .status (grp_status[l*GPL +: GPL]),
                .mask   (grp_mask[l*GPL +: GPL]),
                .irq    (irq_o[l])
            );
        end
    endgenerate

    irqagg_vector #(.DATA_W(STAT_W)) u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (vec_we),
        .wdata (bus_wdata),
        .vec_q (vec_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_space)
                SPACE_IO: begin
                    if (io_stat_hit) begin
                        bus_rdata = grp_status[io_group];
                    end
                end
                SPACE_ACK: begin
                    for (int l = 0; l < NUM_LINES; l++) begin
                        if (bus_addr == ADDR_W'(l * ACK_STRIDE)) begin
                            bus_rdata = vec_q;
                        end
                    end
                end
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
#(
    parameter int NUM_CHANNELS = 8,
    parameter int NUM_GROUPS   = 4,
    parameter int NUM_LINES    = 2,
    parameter int GPL          = 2,
    parameter int ADDR_W       = 8,
    parameter int OFS_W        = 6,
    parameter int STAT_OFS     = 5,
    parameter int VEC_OFS      = 1
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [1:0]                        bus_space,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic                              bus_rd,
    input logic                              bus_wr,
    input logic [STAT_W-1:0]                 bus_wdata,
    input logic [STAT_W-1:0]                 bus_rdata,
    input logic [NUM_CHANNELS-1:0]           set_tx,
    input logic [NUM_CHANNELS-1:0]           set_rx,
    input logic [NUM_CHANNELS-1:0]           set_brk,
    input logic [NUM_CHANNELS-1:0]           clr_tx,
    input logic [NUM_CHANNELS-1:0]           clr_rx,
    input logic [NUM_CHANNELS-1:0]           clr_brk,
    input logic [NUM_LINES-1:0]              irq_o,
    input logic [NUM_GROUPS-1:0][STAT_W-1:0] st,
    input logic [NUM_GROUPS-1:0][STAT_W-1:0] mk,
    input logic [STAT_W-1:0]                 vec
);

    logic [NUM_CHANNELS-1:0][2:0] s_set, s_clr;
    logic                         vec_wr_hit;

    assign vec_wr_hit = bus_wr && (bus_addr == ADDR_W'(VEC_OFS)) &&
                        ((bus_space == SPACE_ID) || (bus_space == SPACE_MEM));

    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_o == '0) && (vec == '0));

    generate
        for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_ch
            assign s_set[c] = {set_brk[c], set_rx[c], set_tx[c]};
            assign s_clr[c] = {clr_brk[c], clr_rx[c], clr_tx[c]};
            for (genvar k = 0; k < 3; k++) begin : g_kind
                localparam int GI = c / 2;
                localparam int BI = (c % 2) * ODD_BASE + k;

                assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    s_set[c][k] |=> st[GI][BI]);

                assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    (st[GI][BI] && !s_clr[c][k]) |=> st[GI][BI]);

                assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    (s_clr[c][k] && !s_set[c][k]) |=> !st[GI][BI]);
            end
        end

        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && (bus_space == SPACE_IO) &&
                 (bus_addr == ADDR_W'((g << OFS_W) | STAT_OFS)))
                |=> (mk[g] == $past(bus_wdata)));
        end

        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            assert_irq_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[l] |-> (|mk[l*GPL +: GPL]));

            assert_irq_needs_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[l] |-> (|st[l*GPL +: GPL]));
        end
    endgenerate

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_space == SPACE_IO)) |-> (!bus_rdata[3] && !bus_rdata[7]));

    assert_ack_odd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_space == SPACE_ACK) && bus_addr[0]) |-> (bus_rdata == '0));

    assert_vec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_wr_hit |=> $stable(vec));

    assert_vec_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_wr_hit |=> (vec == $past(bus_wdata)));

endmodule

bind irq_pair_aggregator irqagg_checker #(
    .NUM_CHANNELS (NUM_CHANNELS),
    .NUM_GROUPS   (NUM_GROUPS),
    .NUM_LINES    (NUM_LINES),
    .GPL          (GPL),
    .ADDR_W       (ADDR_W),
    .OFS_W        (OFS_W),
    .STAT_OFS     (STAT_OFS),
    .VEC_OFS      (VEC_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_space (bus_space),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .set_tx    (set_tx),
    .set_rx    (set_rx),
    .set_brk   (set_brk),
    .clr_tx    (clr_tx),
    .clr_rx    (clr_rx),
    .clr_brk   (clr_brk),
    .irq_o     (irq_o),
    .st        (grp_status),
    .mk        (grp_mask),
    .vec       (vec_q)
);

// File: tb/sim_irq_pair_aggregator.sv
module sim_irq_pair_aggregator;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] SP_IO = 2'd0, SP_ID = 2'd1, SP_ACK = 2'd2, SP_MEM = 2'd3;
    localparam logic [5:0] STAT_OFS = 6'h05;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_space = '0;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] set_tx = '0, set_rx = '0, set_brk = '0;
    logic [7:0] clr_tx = '0, clr_rx = '0, clr_brk = '0;
    logic [1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pair_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .bus_space(bus_space), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .set_tx(set_tx), .set_rx(set_rx), .set_brk(set_brk),
        .clr_tx(clr_tx), .clr_rx(clr_rx), .clr_brk(clr_brk), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sp, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_space = sp; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [1:0] sp, input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_space = sp; bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic read_status(input int g, output logic [7:0] d);
        bus_read(SP_IO, {2'(g), STAT_OFS}, d);
    endtask

    task automatic write_mask(input int g, input logic [7:0] m);
        bus_write(SP_IO, {2'(g), STAT_OFS}, m);
    endtask

    // kind: 0 transmitter ready, 1 receiver ready, 2 break change
    task automatic strobe(input int kind, input int ch, input bit do_set, input bit do_clr);
        @(negedge clk);
        case (kind)
            0: begin set_tx[ch] = do_set; clr_tx[ch] = do_clr; end
            1: begin set_rx[ch] = do_set; clr_rx[ch] = do_clr; end
            default: begin set_brk[ch] = do_set; clr_brk[ch] = do_clr; end
        endcase
        @(negedge clk);
        set_tx = '0; set_rx = '0; set_brk = '0;
        clr_tx = '0; clr_rx = '0; clr_brk = '0;
        #1;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        check("R1 irq during reset", {6'd0, irq_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 irq after reset", {6'd0, irq_o}, 8'h00);
        for (int g = 0; g < 4; g++) begin
            read_status(g, d);
            check("R1 status zero", d, 8'h00);
        end
        bus_read(SP_ACK, 8'h00, d);
        check("R1 vector zero", d, 8'h00);
    endtask

    task automatic t_bit_map();
        logic [7:0] d;
        for (int ch = 0; ch < 8; ch++) begin
            for (int k = 0; k < 3; k++) begin
                strobe(k, ch, 1'b1, 1'b0);
                read_status(ch / 2, d);
                check("R2 set position", d, 8'(1 << (k + 4 * (ch % 2))));
                strobe(k, ch, 1'b0, 1'b1);
                read_status(ch / 2, d);
                check("R3 clear strobe", d, 8'h00);
            end
        end
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        strobe(1, 3, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        read_status(1, d);
        check("R3 bit holds", d, 8'h20);
        strobe(1, 3, 1'b1, 1'b1);
        read_status(1, d);
        check("R3 set wins over clear", d, 8'h20);
        strobe(0, 3, 1'b1, 1'b0);
        strobe(1, 3, 1'b0, 1'b1);
        read_status(1, d);
        check("R3 clear only own bit", d, 8'h10);
        strobe(0, 3, 1'b0, 1'b1);
        read_status(1, d);
        check("R3 group empty", d, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        @(negedge clk);
        set_tx[1:0] = 2'b11; set_rx[1:0] = 2'b11; set_brk[1:0] = 2'b11;
        @(negedge clk);
        set_tx = '0; set_rx = '0; set_brk = '0;
        read_status(0, d);
        check("R4 reserved bits zero", d, 8'h77);
        @(negedge clk);
        clr_tx[1:0] = 2'b11; clr_rx[1:0] = 2'b11; clr_brk[1:0] = 2'b11;
        @(negedge clk);
        clr_tx = '0; clr_rx = '0; clr_brk = '0;
        read_status(0, d);
        check("R4 group cleared", d, 8'h00);
    endtask

    task automatic t_mask_shared();
        logic [7:0] d;
        write_mask(1, 8'hFF);
        read_status(1, d);
        check("R5 read returns status not mask", d, 8'h00);
        check("R5 mask alone no irq", {6'd0, irq_o}, 8'h00);
        strobe(2, 3, 1'b1, 1'b0);
        read_status(1, d);
        check("R5 status after mask write", d, 8'h40);
        check("R5 mask loaded", {6'd0, irq_o}, 8'h01);
    endtask

    task automatic t_unused_io();
        logic [7:0] d;
        bus_read(SP_IO, {2'd1, 6'h06}, d);
        check("R9 other offset reads zero", d, 8'h00);
        bus_read(SP_IO, {2'd1, 6'h04}, d);
        check("R9 other offset reads zero", d, 8'h00);
        bus_write(SP_IO, {2'd1, 6'h06}, 8'h00);
        bus_write(SP_IO, {2'd1, 6'h00}, 8'h00);
        check("R9 mask untouched", {6'd0, irq_o}, 8'h01);
        write_mask(1, 8'h00);
        check("R6 mask cleared drops line", {6'd0, irq_o}, 8'h00);
        strobe(2, 3, 1'b0, 1'b1);
    endtask

    task automatic t_lines();
        strobe(0, 0, 1'b1, 1'b0);
        check("R6 unmasked source quiet", {6'd0, irq_o}, 8'h00);
        write_mask(0, 8'h01);
        check("R6 line0 from group0", {6'd0, irq_o}, 8'h01);
        write_mask(0, 8'h10);
        check("R6 mask on other bit", {6'd0, irq_o}, 8'h00);
        strobe(0, 1, 1'b1, 1'b0);
        check("R6 odd channel raises", {6'd0, irq_o}, 8'h01);
        strobe(0, 1, 1'b0, 1'b1);
        check("R6 clear drops line", {6'd0, irq_o}, 8'h00);
        strobe(0, 0, 1'b0, 1'b1);
        write_mask(0, 8'h00);
        strobe(1, 5, 1'b1, 1'b0);
        write_mask(2, 8'h20);
        check("R6 line1 from group2", {6'd0, irq_o}, 8'h02);
        strobe(2, 7, 1'b1, 1'b0);
        write_mask(3, 8'h40);
        strobe(1, 5, 1'b0, 1'b1);
        check("R6 line1 from group3", {6'd0, irq_o}, 8'h02);
        strobe(2, 7, 1'b0, 1'b1);
        check("R6 line1 drops", {6'd0, irq_o}, 8'h00);
        strobe(1, 2, 1'b1, 1'b0);
        write_mask(1, 8'h02);
        check("R6 line0 from group1", {6'd0, irq_o}, 8'h01);
    endtask

    task automatic t_vector();
        logic [7:0] d;
        bus_write(SP_ID, 8'h01, 8'hA5);
        bus_read(SP_ACK, 8'h00, d);
        check("R7 ack line0", d, 8'hA5);
        bus_read(SP_ACK, 8'h02, d);
        check("R7 ack line1", d, 8'hA5);
        bus_read(SP_ACK, 8'h01, d);
        check("R7 other ack offset", d, 8'h00);
        bus_read(SP_ACK, 8'h04, d);
        check("R7 other ack offset", d, 8'h00);
        check("R7 ack keeps line", {6'd0, irq_o}, 8'h01);
        bus_write(SP_MEM, 8'h01, 8'h3C);
        bus_read(SP_ACK, 8'h02, d);
        check("R8 memory space write", d, 8'h3C);
        bus_write(SP_ID, 8'h03, 8'hFF);
        bus_write(SP_MEM, 8'h00, 8'hFF);
        bus_write(SP_ACK, 8'h01, 8'hFF);
        bus_write(SP_IO, 8'h01, 8'hFF);
        bus_read(SP_ACK, 8'h00, d);
        check("R8 stray writes ignored", d, 8'h3C);
        strobe(1, 2, 1'b0, 1'b1);
        check("R6 final drop", {6'd0, irq_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_bit_map();
        t_sticky();
        t_reserved();
        t_mask_shared();
        t_unused_io();
        t_lines();
        t_vector();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule